// File: doc/BRIEF.md
# TLP Trace Capture Filter

This block sits on the stream of transaction layer packet headers that a PCIe core observes and decides, one header per cycle, which of them a trace engine should record. Each header comes with side information supplied by the core: whether it travels inbound or outbound, its 16-bit requester ID, the index of the core port it belongs to, and its traffic class. The block does not parse the header. It forwards headers that pass the filter on a registered capture output, and it drops the rest after accepting them.

Four configuration inputs steer the decision. The filter word selects either a mask of core ports or a single exact requester ID. The type mask picks packet kinds. The direction code and the entry format together select which directions and completion classes are traced, and the meaning of a direction code depends on the format. A configuration that cannot be honoured raises an error flag and blocks every capture while tracing is enabled. Back-pressure from the consumer holds the captured header in place and stalls the input.

Top module: `tlp_trace_filter`

## Requirements
- R1: After reset, capValid and cfgErr are 0 and inReady is 1.
- R2: A header accepted (inValid and inReady high at a clock edge) that passes the filter appears on capValid/capHdr after that same edge. inReady is high exactly when capValid is low or capReady is high. While capValid is high and capReady is low, capValid and capHdr hold.
- R3: While traceEn is 0, headers are still accepted but none is captured, and cfgErr stays 0.
- R4: With cfgFilter[19]=1 (port mode), a header is kept only when cfgFilter[inPort] is 1. Several port bits may be set at once.
- R5: With cfgFilter[19]=0 (requester mode), a header is kept only when inReqId equals cfgFilter[15:0] exactly.
- R6: inClass encodes 0 posted, 1 non-posted, 2 completion A, 3 completion B. cfgType bit 0 enables posted, bit 1 enables non-posted, and bit 2 enables both completion classes.
- R7: With cfgFmt=0 (4-DW entries), direction code 0 traces all inbound classes, 1 traces outbound, 2 traces outbound plus inbound posted, non-posted and completion B, and 3 traces outbound plus inbound completion A.
- R8: With cfgFmt=1 (8-DW entries), direction code 1 traces outbound only, 2 traces inbound posted, non-posted and completion B, and 3 traces inbound completion A only.
- R9: The configuration is illegal in these cases: cfgType[2:0] is 0; any of cfgType[7:3] is set; outbound tracing is selected and more than one of cfgType[2:0] is set; cfgFilter[18:16] is non-zero; cfgFmt is above 1; cfgDir is above 3; or cfgFmt=1 with cfgDir=0. An illegal configuration with traceEn high sets cfgErr on the next edge and blocks all captures.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| traceEn | input | 1 | Tracing enabled |
| cfgFilter | input | 20 | Bit 19 mode, bits 18:16 reserved, bits 15:0 port mask or requester ID |
| cfgType | input | 8 | Packet kind mask |
| cfgDir | input | 4 | Direction code |
| cfgFmt | input | 4 | Entry format: 0 is 4-DW, 1 is 8-DW |
| inValid | input | 1 | Header present |
| inReady | output | 1 | Header accepted this cycle |
| inHdr | input | HDR_W | Header bits |
| inOutbound | input | 1 | 1 for outbound, 0 for inbound |
| inReqId | input | 16 | Requester ID |
| inPort | input | PORT_IDX_W | Core port index |
| inClass | input | 2 | Traffic class code |
| capValid | output | 1 | Captured header valid |
| capReady | input | 1 | Consumer takes the captured header |
| capHdr | output | HDR_W | Captured header |
| cfgErr | output | 1 | Illegal configuration while enabled |

## Verification
The output hand-off and the loading of a new header can fall in the same cycle: when capValid and capReady are both high, the held header leaves and the next accepted header replaces it on the same edge. The bench provokes this by streaming headers back to back while capReady follows an irregular stall pattern. A scoreboard then judges that no header is lost, duplicated or reordered, and that nothing arrives that the filter model did not predict. A long forced stall also checks that the held header stays put while inReady is low.

// File: rtl/tlp_trace_pkg.sv
package tlp_trace_pkg;

  typedef enum logic [1:0] {
    CLS_P    = 2'd0,
    CLS_NP   = 2'd1,
    CLS_CPLA = 2'd2,
    CLS_CPLB = 2'd3
  } tlpClass_e;

  // strobes from the configuration decoder to the capture datapath
  typedef struct packed {
    logic        block;       // no capture at all
    logic        portMode;    // 1: port mask, 0: requester match
    logic [15:0] filtVal;
    logic        outbEn;      // outbound headers traced
    logic [3:0]  inbClassEn;  // inbound headers traced, indexed by class code
    logic [2:0]  typeSel;     // posted, non-posted, completion
  } capCtl_t;

endpackage

// File: rtl/trace_cfg_ctrl.sv
module trace_cfg_ctrl
  import tlp_trace_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        traceEn,
  input  logic [19:0] cfgFilter,
  input  logic [7:0]  cfgType,
  input  logic [3:0]  cfgDir,
  input  logic [3:0]  cfgFmt,
  output capCtl_t     ctl,
  output logic        cfgErr
);

  logic       fmt8;
  logic       dirBad;
  logic       typeBad;
  logic       filtBad;
  logic       illegal;
  logic       outbEn;
  logic [3:0] inbEn;
  logic [2:0] typeLow;

  assign fmt8    = (cfgFmt == 4'd1);
  assign typeLow = cfgType[2:0];

  // direction decode, meaning depends on entry format
  always_comb begin
    outbEn = 1'b0;
    inbEn  = 4'b0000;
    dirBad = (cfgDir[3:2] != 2'b00) || (cfgFmt[3:1] != 3'b000);
    case ({fmt8, cfgDir[1:0]})
      3'b0_00: inbEn = 4'b1111;
      3'b0_01: outbEn = 1'b1;
      3'b0_10: begin outbEn = 1'b1; inbEn = 4'b1011; end
      3'b0_11: begin outbEn = 1'b1; inbEn = 4'b0100; end
      3'b1_00: dirBad = 1'b1;
      3'b1_01: outbEn = 1'b1;
      3'b1_10: inbEn = 4'b1011;
      3'b1_11: inbEn = 4'b0100;
      default: dirBad = 1'b1;
    endcase
  end

  assign typeBad = (typeLow == 3'b000) || (cfgType[7:3] != 5'd0) ||
                   (outbEn && ((typeLow & (typeLow - 3'd1)) != 3'b000));
  assign filtBad = (cfgFilter[18:16] != 3'b000);
  assign illegal = dirBad || typeBad || filtBad;

  always_comb begin
    ctl.block      = !traceEn || illegal;
    ctl.portMode   = cfgFilter[19];
    ctl.filtVal    = cfgFilter[15:0];
    ctl.outbEn     = outbEn;
    ctl.inbClassEn = inbEn;
    ctl.typeSel    = typeLow;
  end

  always_ff @(posedge clk) begin
    if (!rstN) cfgErr <= 1'b0;
    else       cfgErr <= traceEn && illegal;
  end

  // error flag only ever follows an enabled cycle
  assert_err_gate_R9: assert property (@(posedge clk) disable iff (!rstN)
    !$past(traceEn) |-> !cfgErr);

endmodule

// File: rtl/trace_match_path.sv
module trace_match_path
  import tlp_trace_pkg::*;
#(
  parameter int HDR_W      = 128,
  parameter int NUM_PORTS  = 16,
  parameter int PORT_IDX_W = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  capCtl_t               ctl,
  input  logic                  inValid,
  output logic                  inReady,
  input  logic [HDR_W-1:0]      inHdr,
  input  logic                  inOutbound,
  input  logic [15:0]           inReqId,
  input  logic [PORT_IDX_W-1:0] inPort,
  input  logic [1:0]            inClass,
  output logic                  capValid,
  input  logic                  capReady,
  output logic [HDR_W-1:0]      capHdr
);

  logic [NUM_PORTS-1:0] portSel;
  logic portHit, reqHit, filtHit, typeHit, dirHit, hit, accept;

  genvar g;
  generate
    for (g = 0; g < NUM_PORTS; g++) begin : gPortDec
      assign portSel[g] = (inPort == PORT_IDX_W'(g)) && ctl.filtVal[g];
    end
  endgenerate

  assign portHit = |portSel;
  assign reqHit  = (inReqId == ctl.filtVal);
  assign filtHit = ctl.portMode ? portHit : reqHit;
  assign typeHit = inClass[1] ? ctl.typeSel[2]
                 : (inClass[0] ? ctl.typeSel[1] : ctl.typeSel[0]);
  assign dirHit  = inOutbound ? ctl.outbEn : ctl.inbClassEn[inClass];
  assign hit     = !ctl.block && filtHit && typeHit && dirHit;

  assign inReady = !capValid || capReady;
  assign accept  = inValid && inReady;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      capValid <= 1'b0;
      capHdr   <= '0;
    end else if (accept) begin
      capValid <= hit;
      capHdr   <= inHdr;
    end else if (capReady) begin
      capValid <= 1'b0;
    end
  end

  assert_stall_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    (capValid && !capReady) |=> (capValid && $stable(capHdr)));

  assert_block_R9: assert property (@(posedge clk) disable iff (!rstN)
    (accept && ctl.block) |=> !capValid);

  assert_outb_off_R8: assert property (@(posedge clk) disable iff (!rstN)
    (accept && inOutbound && !ctl.outbEn) |=> !capValid);

endmodule

// File: rtl/tlp_trace_filter.sv
module tlp_trace_filter
  import tlp_trace_pkg::*;
#(
  parameter int HDR_W      = 128,
  parameter int NUM_PORTS  = 16,
  parameter int PORT_IDX_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  traceEn,
  input  logic [19:0]           cfgFilter,
  input  logic [7:0]            cfgType,
  input  logic [3:0]            cfgDir,
  input  logic [3:0]            cfgFmt,
  input  logic                  inValid,
  output logic                  inReady,
  input  logic [HDR_W-1:0]      inHdr,
  input  logic                  inOutbound,
  input  logic [15:0]           inReqId,
  input  logic [PORT_IDX_W-1:0] inPort,
  input  logic [1:0]            inClass,
  output logic                  capValid,
  input  logic                  capReady,
  output logic [HDR_W-1:0]      capHdr,
  output logic                  cfgErr
);

  capCtl_t ctl;

  trace_cfg_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .traceEn(traceEn), .cfgFilter(cfgFilter),
    .cfgType(cfgType), .cfgDir(cfgDir), .cfgFmt(cfgFmt),
    .ctl(ctl), .cfgErr(cfgErr)
  );

  trace_match_path #(.HDR_W(HDR_W), .NUM_PORTS(NUM_PORTS), .PORT_IDX_W(PORT_IDX_W)) uPath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .inValid(inValid), .inReady(inReady),
    .inHdr(inHdr), .inOutbound(inOutbound), .inReqId(inReqId), .inPort(inPort),
    .inClass(inClass), .capValid(capValid), .capReady(capReady), .capHdr(capHdr)
  );

  assert_trace_off_R3: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady && !traceEn) |=> !capValid);

endmodule

// File: tb/tb_tlp_trace_filter.sv
module tb_tlp_trace_filter;

  localparam int HDR_W = 128;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic traceEn = 1'b0;
  logic [19:0] cfgFilter = '0;
  logic [7:0] cfgType = 8'h07;
  logic [3:0] cfgDir = '0;
  logic [3:0] cfgFmt = '0;
  logic inValid = 1'b0;
  logic inReady;
  logic [HDR_W-1:0] inHdr = '0;
  logic inOutbound = 1'b0;
  logic [15:0] inReqId = '0;
  logic [3:0] inPort = '0;
  logic [1:0] inClass = '0;
  logic capValid;
  logic capReady = 1'b1;
  logic [HDR_W-1:0] capHdr;
  logic cfgErr;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int serial = 0;
  bit stallOn = 0;
  bit holdAll = 0;
  logic [HDR_W-1:0] expQ[$];
  string tagQ[$];

  always #2 clk = ~clk;

  tlp_trace_filter #(.HDR_W(HDR_W)) dut (
    .clk(clk), .rstN(rstN), .traceEn(traceEn), .cfgFilter(cfgFilter),
    .cfgType(cfgType), .cfgDir(cfgDir), .cfgFmt(cfgFmt), .inValid(inValid),
    .inReady(inReady), .inHdr(inHdr), .inOutbound(inOutbound), .inReqId(inReqId),
    .inPort(inPort), .inClass(inClass), .capValid(capValid), .capReady(capReady),
    .capHdr(capHdr), .cfgErr(cfgErr)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [HDR_W-1:0] act, input logic [HDR_W-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // independent model of the capture rule
  function automatic bit modelBad();
    bit outSel;
    outSel = (cfgFmt == 0 && cfgDir != 0) || (cfgFmt == 1 && cfgDir == 1);
    if (cfgType[2:0] == 0 || cfgType[7:3] != 0) return 1;
    if (cfgFilter[18:16] != 0 || cfgFmt > 1 || cfgDir > 3) return 1;
    if (cfgFmt == 1 && cfgDir == 0) return 1;
    if (outSel && $countones(cfgType[2:0]) != 1) return 1;
    return 0;
  endfunction

  function automatic bit modelHit(input bit outb, input logic [1:0] cls,
                                  input logic [3:0] port, input logic [15:0] rid);
    bit dirOk, typeOk, filtOk;
    if (!traceEn || modelBad()) return 0;
    if (outb) dirOk = (cfgFmt == 0 && cfgDir != 0) || (cfgFmt == 1 && cfgDir == 1);
    else if (cfgFmt == 0 && cfgDir == 0) dirOk = 1;
    else if (cfgDir == 2) dirOk = (cls != 2);
    else if (cfgDir == 3) dirOk = (cls == 2);
    else dirOk = 0;
    case (cls)
      2'd0: typeOk = cfgType[0];
      2'd1: typeOk = cfgType[1];
      default: typeOk = cfgType[2];
    endcase
    filtOk = cfgFilter[19] ? cfgFilter[port] : (rid == cfgFilter[15:0]);
    return dirOk && typeOk && filtOk;
  endfunction

  task automatic send(input bit outb, input logic [1:0] cls, input logic [3:0] port,
                      input logic [15:0] rid, input string tag);
    logic [HDR_W-1:0] h;
    serial++;
    h = {4{32'(serial) ^ 32'hA5C30000}};
    inHdr = h; inOutbound = outb; inClass = cls; inPort = port; inReqId = rid;
    inValid = 1'b1;
    forever begin
      @(negedge clk);
      if (inReady) break;
    end
    if (modelHit(outb, cls, port, rid)) begin
      expQ.push_back(h);
      tagQ.push_back(tag);
    end
    @(posedge clk); #1;
    inValid = 1'b0;
  endtask

  task automatic drain();
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (expQ.size() == 0 && !capValid) break;
    end
    check(expQ.size() == 0, "R2", "scoreboard drained", HDR_W'(expQ.size()), '0);
    @(posedge clk); #1;
  endtask

  task automatic setCfg(input bit en, input logic [19:0] f, input logic [7:0] t,
                        input logic [3:0] d, input logic [3:0] fm);
    traceEn = en; cfgFilter = f; cfgType = t; cfgDir = d; cfgFmt = fm;
  endtask

  // consumer ready pattern
  initial forever begin
    @(posedge clk); #1;
    cyc++;
    capReady = holdAll ? 1'b0 : (stallOn ? !((cyc % 5 == 3) || (cyc % 7 == 2)) : 1'b1);
  end

  // scoreboard monitor
  initial forever begin
    @(negedge clk);
    if (rstN && capValid && capReady) begin
      if (expQ.size() == 0) begin
        check(0, "R2", "unexpected capture", capHdr, '0);
      end else begin
        logic [HDR_W-1:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check(capHdr == e, t, "captured header", capHdr, e);
      end
    end
  end

  initial begin
    #400000;
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=done");
    finishRun();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    check(capValid == 0, "R1", "capValid", HDR_W'(capValid), '0);
    check(cfgErr == 0, "R1", "cfgErr", HDR_W'(cfgErr), '0);
    check(inReady == 1, "R1", "inReady", HDR_W'(inReady), 1);
    @(posedge clk); #1; rstN = 1'b1;
    @(posedge clk); #1;

    // R2 latency: capture visible right after the acceptance edge
    setCfg(1, 20'h80005, 8'h07, 4'd0, 4'd0);
    send(0, 2'd0, 4'd0, 16'h0, "R2");
    @(negedge clk);
    check(capValid == 1, "R2", "capValid one cycle after accept", HDR_W'(capValid), 1);
    drain();

    // R2 hold under back-pressure
    holdAll = 1;
    @(posedge clk); #1;
    send(0, 2'd1, 4'd2, 16'h0, "R2");
    repeat (3) @(negedge clk);
    check(capValid == 1 && inReady == 0, "R2", "stalled hold", HDR_W'({capValid, inReady}), 2);
    holdAll = 0;
    drain();

    stallOn = 1;
    // R4 port mask over ports 0 and 2, all inbound classes (R7 code 0)
    for (int p = 0; p < 6; p++)
      for (int c = 0; c < 4; c++) send(0, 2'(c), 4'(p), 16'h1234, "R4");
    send(1, 2'd0, 4'd0, 16'h0, "R7");
    drain();

    // R5 requester match, reserved bits clear
    setCfg(1, 20'h00101, 8'h07, 4'd0, 4'd0);
    send(0, 2'd0, 4'd3, 16'h0101, "R5");
    send(0, 2'd1, 4'd3, 16'h0100, "R5");
    send(0, 2'd3, 4'd3, 16'h0111, "R5");
    send(0, 2'd2, 4'd9, 16'h0101, "R5");
    send(0, 2'd0, 4'd3, 16'h8101, "R5");
    drain();

    // R6 type mask: non-posted only
    setCfg(1, 20'h8FFFF, 8'h02, 4'd0, 4'd0);
    for (int c = 0; c < 4; c++) send(0, 2'(c), 4'd5, 16'h0, "R6");
    setCfg(1, 20'h8FFFF, 8'h05, 4'd0, 4'd0);
    for (int c = 0; c < 4; c++) send(0, 2'(c), 4'd6, 16'h0, "R6");
    drain();

    // R7 4-DW direction codes
    setCfg(1, 20'h8FFFF, 8'h04, 4'd2, 4'd0);
    for (int c = 0; c < 4; c++) begin
      send(0, 2'(c), 4'd1, 16'h0, "R7");
      send(1, 2'(c), 4'd1, 16'h0, "R7");
    end
    setCfg(1, 20'h8FFFF, 8'h04, 4'd3, 4'd0);
    for (int c = 0; c < 4; c++) begin
      send(0, 2'(c), 4'd1, 16'h0, "R7");
      send(1, 2'(c), 4'd1, 16'h0, "R7");
    end
    setCfg(1, 20'h8FFFF, 8'h01, 4'd1, 4'd0);
    send(1, 2'd0, 4'd4, 16'h0, "R7");
    send(0, 2'd0, 4'd4, 16'h0, "R7");
    drain();

    // R8 8-DW direction codes
    setCfg(1, 20'h8FFFF, 8'h02, 4'd1, 4'd1);
    send(1, 2'd1, 4'd7, 16'h0, "R8");
    send(0, 2'd1, 4'd7, 16'h0, "R8");
    setCfg(1, 20'h8FFFF, 8'h07, 4'd2, 4'd1);
    for (int c = 0; c < 4; c++) begin
      send(0, 2'(c), 4'd7, 16'h0, "R8");
      send(1, 2'(c), 4'd7, 16'h0, "R8");
    end
    setCfg(1, 20'h8FFFF, 8'h07, 4'd3, 4'd1);
    for (int c = 0; c < 4; c++) send(0, 2'(c), 4'd7, 16'h0, "R8");
    drain();

    // R9 illegal configurations
    setCfg(1, 20'h8FFFF, 8'h07, 4'd0, 4'd1);
    repeat (2) @(negedge clk);
    check(cfgErr == 1, "R9", "cfgErr 8-DW code 0", HDR_W'(cfgErr), 1);
    @(posedge clk); #1;
    for (int c = 0; c < 4; c++) send(0, 2'(c), 4'd0, 16'h0, "R9");
    setCfg(1, 20'h8FFFF, 8'h03, 4'd1, 4'd0);
    repeat (2) @(negedge clk);
    check(cfgErr == 1, "R9", "cfgErr outbound multi-type", HDR_W'(cfgErr), 1);
    @(posedge clk); #1;
    send(1, 2'd0, 4'd0, 16'h0, "R9");
    setCfg(1, 20'h8FFFF, 8'h00, 4'd0, 4'd0);
    repeat (2) @(negedge clk);
    check(cfgErr == 1, "R9", "cfgErr empty type", HDR_W'(cfgErr), 1);
    setCfg(1, 20'h10101, 8'h07, 4'd0, 4'd0);
    repeat (2) @(negedge clk);
    check(cfgErr == 1, "R9", "cfgErr reserved filter bits", HDR_W'(cfgErr), 1);
    @(posedge clk); #1;
    send(0, 2'd0, 4'd0, 16'h0101, "R9");
    drain();

    // R3 tracing disabled: accepted, nothing captured, no error
    setCfg(0, 20'h8FFFF, 8'h00, 4'd0, 4'd1);
    repeat (2) @(negedge clk);
    check(cfgErr == 0, "R3", "cfgErr while disabled", HDR_W'(cfgErr), 0);
    @(posedge clk); #1;
    setCfg(0, 20'h8FFFF, 8'h07, 4'd0, 4'd0);
    for (int c = 0; c < 4; c++) send(0, 2'(c), 4'd2, 16'h0, "R3");
    @(negedge clk);
    check(capValid == 0, "R3", "no capture while disabled", HDR_W'(capValid), 0);
    drain();

    finishRun();
  end

endmodule